// File: doc/BRIEF.md
# Ordered Soft Reset Sequencer

This controller takes the sub-blocks of a network MAC through a fixed soft-reset procedure. It drives six level outputs: a reset for the physical coding sublayer, a reset for the MAC core, resets for the receive and transmit FIFOs, and flush controls for both FIFOs. A single-cycle start request launches eight ordered steps. Each step raises or lowers a fixed subset of these outputs and leaves the others as they are. Consecutive steps are spaced by a programmable gap, and the gap never drops below a minimum count of the line-side clock. When the last gap has run out, the controller pulses done and turns receive-enable back on.

Software runs this procedure after it changes most configuration settings. The exceptions are receive-enable, the pause-timing control and the reset controls themselves. A separate path watches the management-interface soft reset. After that reset is released, the path holds the management access grant low for a fixed number of host-clock cycles. An asynchronous hard reset forces every reset and flush output high, clears receive-enable and returns the sequencer to idle.

Top module: `soft_rst_seq`

## Requirements
- R1: While hard reset `rst_n` is low, all six reset/flush outputs are 1 and `rx_en_o`, `busy_o`, `done_o` and `mgmt_access_ok_o` are 0. A hard reset in the middle of a sequence aborts it.
- R2: A start request sampled at clock edge k while idle sets `busy_o` at edge k and applies step 1 (the sublayer reset goes to 1) at the same edge.
- R3: The steps act in this order. Step 1 sets the sublayer reset. Step 2 sets the MAC core reset and both FIFO resets. Step 3 sets both flushes. Step 4 clears the receive flush. Step 5 clears the receive FIFO reset. Step 6 clears the sublayer reset. Step 7 clears the MAC core reset and the transmit FIFO reset. Step 8 clears the transmit flush. No step changes any output it does not name.
- R4: The gap is G = max(`gap_i`, MIN_GAP), and `gap_i` is sampled only at start. Step n takes effect at edge k+(n-1)·G. All outputs hold steady between steps.
- R5: At edge k+8·G, `busy_o` falls and all six reset/flush outputs are 0. `done_o` is 1 for exactly that one cycle.
- R6: A start request sampled while `busy_o` is 1 is ignored. This includes the final cycle before completion.
- R7: `rx_en_o` is 0 from edge k until completion. It is 1 from edge k+8·G until the next accepted start.
- R8: `mgmt_access_ok_o` is 0 while `mgmt_rst_i` is 1. It rises at the HOLD-th consecutive clock edge that samples `mgmt_rst_i` low after a reset or release.
- R9: If `mgmt_rst_i` is raised again during the hold-off, the count restarts from zero at the next release.
- R10: The sequencer and the management hold-off run independently of each other. Both may update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and the hold-off counter |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| start_i | input | 1 | Single-cycle request to run the soft-reset procedure |
| gap_i | input | GAP_W | Requested spacing between steps, in cycles |
| mgmt_rst_i | input | 1 | Management-interface soft reset, active high |
| pcs_rst_o | output | 1 | Physical coding sublayer reset |
| mac_rst_o | output | 1 | MAC core reset |
| rxf_rst_o | output | 1 | Receive FIFO reset |
| txf_rst_o | output | 1 | Transmit FIFO reset |
| rx_flush_o | output | 1 | Receive FIFO flush |
| tx_flush_o | output | 1 | Transmit FIFO flush |
| rx_en_o | output | 1 | Receive enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| mgmt_access_ok_o | output | 1 | Management register access permitted |

## Verification
Two functions can update in the same clock cycle: sequence completion (the done pulse and receive-enable rising) and the end of the management hold-off (the access grant rising). The bench provokes this deliberately. During a sequence it releases the management reset exactly HOLD-1 edges before the edge at which completion is due, so both outputs change on the same edge. Every output is then compared in that cycle and in the cycles on either side, using a cycle-accurate model computed in the bench. A mismatch in either output shows that one path disturbed the other.

// File: rtl/soft_rst_pkg.sv
package soft_rst_pkg;

    localparam int unsigned NUM_STEPS = 8;
    localparam int unsigned STEP_W    = 4;

    typedef struct packed {
        logic pcs;
        logic mac;
        logic rxf;
        logic txf;
        logic rxfl;
        logic txfl;
    } rst_vec_t;

    localparam rst_vec_t RST_ALL_ON  = '1;
    localparam rst_vec_t RST_ALL_OFF = '0;

    // Apply one step of the procedure to the current control vector.
    function automatic rst_vec_t step_apply(rst_vec_t cur, logic [STEP_W-1:0] step);
        rst_vec_t nxt;
        nxt = cur;
        case (step)
            4'd1: nxt.pcs = 1'b1;
            4'd2: begin
                nxt.mac = 1'b1;
                nxt.rxf = 1'b1;
                nxt.txf = 1'b1;
            end
            4'd3: begin
                nxt.rxfl = 1'b1;
                nxt.txfl = 1'b1;
            end
            4'd4: nxt.rxfl = 1'b0;
            4'd5: nxt.rxf  = 1'b0;
            4'd6: nxt.pcs  = 1'b0;
            4'd7: begin
                nxt.mac = 1'b0;
                nxt.txf = 1'b0;
            end
            4'd8: nxt.txfl = 1'b0;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/soft_rst_gap_timer.sv
module soft_rst_gap_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.cnt = len_i - CNT_W'(1);
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign expired_o = (t_q.cnt == '0);

    // R4: a freshly loaded interval is never reported as already elapsed
    assert_load_not_expired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i > CNT_W'(1)) |=> !expired_o);

endmodule

// File: rtl/soft_rst_step_ctl.sv
module soft_rst_step_ctl
    import soft_rst_pkg::*;
#(
    parameter int unsigned GAP_W   = 8,
    parameter int unsigned MIN_GAP = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [GAP_W-1:0] load_len_o,
    output rst_vec_t         ctl_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             rx_en_o
);

    localparam logic [GAP_W-1:0]  MIN_GAP_V = GAP_W'(MIN_GAP);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [GAP_W-1:0]  gap;
        rst_vec_t          ctl;
        logic              busy;
        logic              done;
        logic              rxen;
    } seq_t;

    seq_t s_d, s_q;
    logic [GAP_W-1:0] gap_eff;

    assign gap_eff = (gap_i < MIN_GAP_V) ? MIN_GAP_V : gap_i;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        load_o     = 1'b0;
        load_len_o = s_q.gap;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy   = 1'b1;
                s_d.step   = STEP_W'(1);
                s_d.gap    = gap_eff;
                s_d.ctl    = step_apply(s_q.ctl, STEP_W'(1));
                s_d.rxen   = 1'b0;
                load_o     = 1'b1;
                load_len_o = gap_eff;
            end
        end else if (expired_i) begin
            if (s_q.step == LAST_STEP) begin
                s_d.busy = 1'b0;
                s_d.step = '0;
                s_d.done = 1'b1;
                s_d.rxen = 1'b1;
            end else begin
                s_d.step = s_q.step + STEP_W'(1);
                s_d.ctl  = step_apply(s_q.ctl, s_q.step + STEP_W'(1));
                load_o   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.step <= '0;
            s_q.gap  <= MIN_GAP_V;
            s_q.ctl  <= RST_ALL_ON;
            s_q.busy <= 1'b0;
            s_q.done <= 1'b0;
            s_q.rxen <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o   = s_q.ctl;
    assign busy_o  = s_q.busy;
    assign done_o  = s_q.done;
    assign rx_en_o = s_q.rxen;

    // R7: reception stays off for the whole sequence
    assert_rx_off_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> !s_q.rxen);

    // R4: controls hold steady until the interval timer reports expiry
    assert_hold_between_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !expired_i) |=> $stable(s_q.ctl));

    // R6: a start during a sequence does not move the step index backwards
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && start_i && !expired_i) |=> $stable(s_q.step));

    // R5: completion leaves every control released and reception on
    assert_done_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (s_q.ctl == RST_ALL_OFF && s_q.rxen && !s_q.busy));

    // R5: done is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

endmodule

// File: rtl/soft_rst_mgmt_hold.sv
module soft_rst_mgmt_hold #(
    parameter int unsigned HOLD_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mgmt_rst_i,
    output logic access_ok_o
);

    localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_V = HOLD_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              ok;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (mgmt_rst_i) begin
            h_d.cnt = HOLD_V;
            h_d.ok  = 1'b0;
        end else if (h_q.cnt > HOLD_W'(1)) begin
            h_d.cnt = h_q.cnt - HOLD_W'(1);
        end else if (h_q.cnt == HOLD_W'(1)) begin
            h_d.cnt = '0;
            h_d.ok  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.cnt <= HOLD_V;
            h_q.ok  <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign access_ok_o = h_q.ok;

    // R8: access is withdrawn the cycle after the management reset is seen
    assert_blocked_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rst_i |=> !access_ok_o);

    // R9: the grant only rises out of a released state
    assert_grant_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok_o) |-> !$past(mgmt_rst_i));

endmodule

// File: rtl/soft_rst_seq.sv
module soft_rst_seq
    import soft_rst_pkg::*;
#(
    parameter int unsigned GAP_W       = 8,
    parameter int unsigned MIN_GAP     = 20,
    parameter int unsigned HOLD_CYCLES = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             mgmt_rst_i,
    output logic             pcs_rst_o,
    output logic             mac_rst_o,
    output logic             rxf_rst_o,
    output logic             txf_rst_o,
    output logic             rx_flush_o,
    output logic             tx_flush_o,
    output logic             rx_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             mgmt_access_ok_o
);

    logic             tmr_load;
    logic [GAP_W-1:0] tmr_len;
    logic             tmr_expired;
    rst_vec_t         ctl;

    soft_rst_step_ctl #(
        .GAP_W   (GAP_W),
        .MIN_GAP (MIN_GAP)
    ) u_step_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .gap_i      (gap_i),
        .expired_i  (tmr_expired),
        .load_o     (tmr_load),
        .load_len_o (tmr_len),
        .ctl_o      (ctl),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .rx_en_o    (rx_en_o)
    );

    soft_rst_gap_timer #(
        .CNT_W (GAP_W)
    ) u_gap_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_expired)
    );

    soft_rst_mgmt_hold #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_mgmt_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .mgmt_rst_i  (mgmt_rst_i),
        .access_ok_o (mgmt_access_ok_o)
    );

    assign pcs_rst_o  = ctl.pcs;
    assign mac_rst_o  = ctl.mac;
    assign rxf_rst_o  = ctl.rxf;
    assign txf_rst_o  = ctl.txf;
    assign rx_flush_o = ctl.rxfl;
    assign tx_flush_o = ctl.txfl;

    // R2: an accepted start takes effect on the very next edge
    assert_start_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && pcs_rst_o && !rx_en_o));

endmodule

// File: tb/soft_rst_seq_bench.sv
`timescale 1ns/1ps
module soft_rst_seq_bench;

    localparam int GAP_W   = 8;
    localparam int MIN_GAP = 20;
    localparam int HOLD    = 60;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_r;
    logic [GAP_W-1:0] gap_r;
    logic             mgmt_r;
    logic pcs, mac, rxf, txf, rxfl, txfl, rxen, busy, done, ok;

    int n_cmp  = 0;
    int n_fail = 0;

    // model state
    logic [5:0] m_vec;
    logic       m_busy, m_done, m_rxen, m_ok;
    int         m_t, m_g, m_low;

    always #10 clk = ~clk;

    soft_rst_seq #(
        .GAP_W(GAP_W), .MIN_GAP(MIN_GAP), .HOLD_CYCLES(HOLD)
    ) u_soft_rst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_r), .gap_i(gap_r),
        .mgmt_rst_i(mgmt_r),
        .pcs_rst_o(pcs), .mac_rst_o(mac), .rxf_rst_o(rxf), .txf_rst_o(txf),
        .rx_flush_o(rxfl), .tx_flush_o(txfl), .rx_en_o(rxen),
        .busy_o(busy), .done_o(done), .mgmt_access_ok_o(ok)
    );

    // bit order: [5] sublayer, [4] core, [3] rx fifo, [2] tx fifo, [1] rx flush, [0] tx flush
    function automatic logic [5:0] apply_step(logic [5:0] v, int n);
        logic [5:0] r;
        r = v;
        case (n)
            1: r[5] = 1'b1;
            2: r[4:2] = 3'b111;
            3: r[1:0] = 2'b11;
            4: r[1] = 1'b0;
            5: r[3] = 1'b0;
            6: r[5] = 1'b0;
            7: begin r[4] = 1'b0; r[2] = 1'b0; end
            8: r[0] = 1'b0;
            default: r = v;
        endcase
        return r;
    endfunction

    task automatic model_reset();
        m_vec = 6'b111111; m_busy = 0; m_done = 0; m_rxen = 0;
        m_ok = 0; m_low = 0; m_t = 0; m_g = MIN_GAP;
    endtask

    task automatic model_edge();
        m_done = 0;
        if (!m_busy) begin
            if (start_r) begin
                m_busy = 1; m_t = 0;
                m_g = (int'(gap_r) < MIN_GAP) ? MIN_GAP : int'(gap_r);
                m_vec = apply_step(m_vec, 1); m_rxen = 0;
            end
        end else begin
            m_t++;
            if (m_t == 8 * m_g) begin
                m_busy = 0; m_done = 1; m_rxen = 1;
            end else if (m_t % m_g == 0) begin
                m_vec = apply_step(m_vec, m_t / m_g + 1);
            end
        end
        if (mgmt_r) begin
            m_low = 0; m_ok = 0;
        end else begin
            if (m_low < HOLD) m_low++;
            m_ok = (m_low >= HOLD);
        end
    endtask

    task automatic compare(string tag);
        logic [9:0] act, exp;
        act = {pcs, mac, rxf, txf, rxfl, txfl, busy, done, rxen, ok};
        exp = {m_vec, m_busy, m_done, m_rxen, m_ok};
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%b expected=%b", tag, m_t, act, exp);
        end
    endtask

    // one clock: inputs already driven at a negedge, model at the edge, sample at next negedge
    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        start_r = 1'b0;
    endtask

    // run a full sequence; inject extra starts at t1/t2; release mgmt at t = fall (if >= 0)
    task automatic run_seq(int gap, int t1, int t2, int fall, string tag);
        int g;
        g = (gap < MIN_GAP) ? MIN_GAP : gap;
        gap_r = GAP_W'(gap);
        start_r = 1'b1;
        if (fall == 0) mgmt_r = 1'b0;
        cyc(tag);
        gap_r = '0;  // R4: later changes must not alter the latched gap
        for (int t = 1; t <= 8 * g + 2; t++) begin
            start_r = (t == t1 || t == t2);
            if (fall >= 0) mgmt_r = (t < fall);
            cyc(tag);
        end
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        #1;
        model_reset();
        compare("R1");
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_r = 1'b0; gap_r = '0; mgmt_r = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        // R8: hold-off counted from release
        mgmt_r = 1'b0;
        for (int i = 0; i < HOLD + 5; i++) cyc("R8");
        // R9: re-assert mid hold-off restarts the count
        mgmt_r = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R8");
        mgmt_r = 1'b0;
        for (int i = 0; i < 30; i++) cyc("R9");
        mgmt_r = 1'b1;
        cyc("R9");
        mgmt_r = 1'b0;
        for (int i = 0; i < HOLD + 3; i++) cyc("R9");

        // R2 R3 R4 R5 R7: sweep of gap values, first run from the hard-reset state
        run_seq(0,  -1, -1, -1, "R2 R3 R4 R5 R7");
        run_seq(5,  -1, -1, -1, "R3 R4");
        run_seq(19, -1, -1, -1, "R4");
        run_seq(20, -1, -1, -1, "R4 R5");
        run_seq(21, -1, -1, -1, "R4");
        run_seq(33, -1, -1, -1, "R3 R4 R7");
        // R6: starts while busy, including the last busy cycle
        run_seq(20, 30, 159, -1, "R6");
        run_seq(25, 1,  199, -1, "R6");
        for (int i = 0; i < 4; i++) cyc("R7");

        // R10: grant rises on the same edge as completion (t = 160, release at 101)
        mgmt_r = 1'b1;
        for (int i = 0; i < 2; i++) cyc("R10");
        run_seq(20, -1, -1, 160 - HOLD + 1, "R10");
        // R10: grant rises mid-sequence while steps advance
        mgmt_r = 1'b1;
        cyc("R10");
        run_seq(24, -1, -1, 24 * 3 - HOLD + 1, "R10");

        // R1: hard reset in the middle of a sequence
        gap_r = 8'd20; start_r = 1'b1;
        cyc("R1");
        for (int i = 0; i < 50; i++) cyc("R1");
        hard_reset();
        run_seq(22, -1, -1, -1, "R1 R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule